// File: doc/BRIEF.md
# 5b6b DC-Balanced Line Encoder

This block turns a stream of 5-bit data words into 6-bit line code words whose mean level stays at zero. Every accepted word produces exactly one code word one clock later. The block keeps a running disparity: the count of ones sent so far minus the count of zeros. That count is held to the set {-2, 0, +2}, so a receiver's baseline never drifts.

An odd-width input always has an odd disparity. Words with one more one than zeros, or one more zero than ones, are padded with a single low-order bit that evens the count to three ones and three zeros. Words with a disparity of magnitude three or five are looked up in a twelve-entry table. Each entry holds one code word with four ones. The block sends that word, or its bitwise complement, whichever pulls the running disparity back toward zero. Serialization, decoding and control symbols lie outside this block.

Top module: `dcb56_encoder`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle in which `inValid` was sampled high outside reset, and low in every other cycle.
- R2: An input with two or three ones is sent as `outCode[5:1] = inWord` and `outCode[0]` = 1 when the input has two ones, 0 when it has three ones.
- R3: Each input with 0, 1, 4 or 5 ones maps to a stored code with four ones: 00000→010111, 00001→100111, 00010→011011, 00100→101011, 01000→110011, 10000→011101, 11110→110110, 11101→101110, 11011→111001, 10111→110101, 01111→101101, 11111→111010.
- R4: A table input is sent as its stored code when the running disparity before the word is 0 or -2, and as the bitwise complement of its stored code when the running disparity is +2.
- R5: `runDisp` reports the running disparity after the last code word sent, encoded 2'b00 = 0, 2'b01 = +2, 2'b11 = -2. A code with three ones leaves it unchanged, a code with four ones adds 2 and a code with two ones subtracts 2. It never takes any other value.
- R6: A synchronous `rst` sampled high clears `outValid` and sets `runDisp` to 2'b00 at that clock edge.
- R7: In a cycle where `inValid` is low, `runDisp` and `outCode` keep their values at the next edge.
- R8: No two distinct input words produce the same code word, in whichever disparity state each was encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word strobe |
| inWord | input | 5 | Data word to encode |
| outValid | output | 1 | Code word strobe, one cycle after `inValid` |
| outCode | output | 6 | Encoded line word |
| runDisp | output | 2 | Running disparity after the last code word |

## Verification
On every cycle the assertions check the following. The valid strobe follows its input by one cycle. Every emitted code has two, three or four ones. The disparity register stays in its three legal states and holds over idle cycles. A four-ones code is never sent from the +2 state, and always leaves the register at +2. Only the bench's scenarios can show the exact code for each of the 32 inputs in both disparity states, the contents of the stored table, and that the code set is free of collisions. They also cover long random streams, where output is compared against an independent model.

// File: rtl/enc56_pkg.sv
package enc56_pkg;

  localparam int DATA_W = 5;
  localparam int CODE_W = DATA_W + 1;
  localparam int HALF_W = CODE_W / 2;

  // Running-disparity encoding seen at the status port
  typedef enum logic [1:0] {
    RD_ZERO = 2'b00,
    RD_POS  = 2'b01,
    RD_NEG  = 2'b11
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new code word
    logic invert;  // send complement of the stored code
  } encStrobe_t;

  // Stored member (four ones) for inputs of disparity +/-3 or +/-5
  function automatic logic [CODE_W-1:0] storedCode(input logic [DATA_W-1:0] w);
    logic [CODE_W-1:0] c;
    unique case (w)
      5'b00000: c = 6'b010111;
      5'b00001: c = 6'b100111;
      5'b00010: c = 6'b011011;
      5'b00100: c = 6'b101011;
      5'b01000: c = 6'b110011;
      5'b10000: c = 6'b011101;
      5'b11110: c = 6'b110110;
      5'b11101: c = 6'b101110;
      5'b11011: c = 6'b111001;
      5'b10111: c = 6'b110101;
      5'b01111: c = 6'b101101;
      5'b11111: c = 6'b111010;
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/enc56_dpath.sv
module enc56_dpath
  import enc56_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inWord,
  input  encStrobe_t        strb,
  output logic              isPaired,
  output logic [CODE_W-1:0] outCode
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  onesCnt;
  logic              padBit;
  logic [CODE_W-1:0] tableCode;
  logic [CODE_W-1:0] rawCode;
  logic [CODE_W-1:0] codeReg;

  // Population count of the input word
  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < DATA_W; i++) begin
      onesCnt = onesCnt + CNT_W'(inWord[i]);
    end
  end

  // Two or three ones: balanced by one pad bit; otherwise table entry
  assign isPaired  = (onesCnt != CNT_W'(HALF_W - 1)) && (onesCnt != CNT_W'(HALF_W));
  assign padBit    = (onesCnt == CNT_W'(HALF_W - 1));
  assign tableCode = storedCode(inWord);

  always_comb begin
    if (isPaired) begin
      rawCode = strb.invert ? ~tableCode : tableCode;
    end else begin
      rawCode = {inWord, padBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeReg <= '0;
    end else if (strb.load) begin
      codeReg <= rawCode;
    end
  end

  assign outCode = codeReg;

  // R2: a padded word is always balanced
  always_comb begin
    if (!rst && strb.load && !isPaired) begin
      a_r2_pad_balanced: assert ($countones(rawCode) == HALF_W);
    end
  end

  // R3: a table word is unbalanced by exactly two
  always_comb begin
    if (!rst && strb.load && isPaired) begin
      a_r3_table_weight: assert ($countones(rawCode) == HALF_W + 1 ||
                                 $countones(rawCode) == HALF_W - 1);
    end
  end

  // R7: code held over idle cycles
  a_r7_code_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(codeReg));

endmodule

// File: rtl/enc56_ctrl.sv
module enc56_ctrl
  import enc56_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       isPaired,
  output encStrobe_t strb,
  output logic       outValid,
  output rdState_t   rdState
);

  rdState_t rdReg;
  rdState_t rdNext;
  logic     validReg;

  assign strb.load   = inValid;
  assign strb.invert = (rdReg == RD_POS);

  // Table words move the disparity toward zero; padded words leave it alone
  always_comb begin
    rdNext = rdReg;
    if (inValid && isPaired) begin
      unique case (rdReg)
        RD_POS:  rdNext = RD_ZERO;
        RD_ZERO: rdNext = RD_POS;
        RD_NEG:  rdNext = RD_ZERO;
        default: rdNext = RD_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdReg    <= RD_ZERO;
      validReg <= 1'b0;
    end else begin
      rdReg    <= rdNext;
      validReg <= inValid;
    end
  end

  assign outValid = validReg;
  assign rdState  = rdReg;

  // R1: output strobe trails the input strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R5: only three legal disparity states
  a_r5_rd_legal: assert property (@(posedge clk) disable iff (rst)
    rdReg == RD_ZERO || rdReg == RD_POS || rdReg == RD_NEG);

  // R7: idle cycles do not touch the disparity
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(rdReg));

endmodule

// File: rtl/dcb56_encoder.sv
module dcb56_encoder
  import enc56_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inWord,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode,
  output logic [1:0]        runDisp
);

  encStrobe_t strb;
  logic       isPaired;
  rdState_t   rdState;

  enc56_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .isPaired (isPaired),
    .strb     (strb),
    .outValid (outValid),
    .rdState  (rdState)
  );

  enc56_dpath i_dpath (
    .clk      (clk),
    .rst      (rst),
    .inWord   (inWord),
    .strb     (strb),
    .isPaired (isPaired),
    .outCode  (outCode)
  );

  assign runDisp = rdState;

  // R5: every emitted word has two, three or four ones
  a_r5_code_weight: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($countones(outCode) >= HALF_W - 1 && $countones(outCode) <= HALF_W + 1));

  // R4: a four-ones word is never sent from +2 and always lands on +2
  a_r4_heavy_from_low: assert property (@(posedge clk) disable iff (rst)
    inValid && isPaired && rdState == RD_POS |=> $countones(outCode) == HALF_W - 1);
  a_r5_heavy_lands_pos: assert property (@(posedge clk) disable iff (rst)
    outValid && $countones(outCode) == HALF_W + 1 |-> runDisp == 2'b01);

endmodule

// File: tb/test_dcb56_encoder.sv
module test_dcb56_encoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [4:0] inWord = '0;
  logic       outValid;
  logic [5:0] outCode;
  logic [1:0] runDisp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dcb56_encoder i_dcb56_encoder (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inWord   (inWord),
    .outValid (outValid),
    .outCode  (outCode),
    .runDisp  (runDisp)
  );

  // {input word, stored four-ones code} from R3
  localparam logic [10:0] PAIR_TAB [12] = '{
    {5'b00000, 6'b010111}, {5'b00001, 6'b100111}, {5'b00010, 6'b011011},
    {5'b00100, 6'b101011}, {5'b01000, 6'b110011}, {5'b10000, 6'b011101},
    {5'b11110, 6'b110110}, {5'b11101, 6'b101110}, {5'b11011, 6'b111001},
    {5'b10111, 6'b110101}, {5'b01111, 6'b101101}, {5'b11111, 6'b111010}
  };

  int modelRd = 0;   // running disparity, -2/0/+2
  int seenBy [64];

  function automatic logic [5:0] expCode(input logic [4:0] w, input int rd);
    int n = $countones(w);
    if (n == 2) return {w, 1'b1};
    if (n == 3) return {w, 1'b0};
    for (int k = 0; k < 12; k++) begin
      if (PAIR_TAB[k][10:6] == w) return (rd == 2) ? ~PAIR_TAB[k][5:0] : PAIR_TAB[k][5:0];
    end
    return 6'b000000;
  endfunction

  function automatic logic [1:0] rdEnc(input int rd);
    if (rd == 2)  return 2'b01;
    if (rd == -2) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    modelRd = 0;
  endtask

  // Drive one word, sample one cycle later, check code and disparity
  task automatic sendWord(input logic [4:0] w, input string req);
    logic [5:0] exp;
    exp = expCode(w, modelRd);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    @(negedge clk);
    inValid = 1'b0;
    modelRd = modelRd + 2 * ($countones(exp) - 3);
    check(outValid == 1'b1, "R1", outValid, 1);
    check(outCode == exp, req, outCode, exp);
    check(runDisp == rdEnc(modelRd), "R5", runDisp, rdEnc(modelRd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    logic [1:0] heldRd;
    for (int i = 0; i < 64; i++) seenBy[i] = -1;

    // R6: reset state
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R6", outValid, 0);
    check(runDisp == 2'b00, "R6", runDisp, 0);
    rst = 1'b0;

    // Table walk: every input at both disparity states
    for (int w = 0; w < 32; w++) begin
      for (int st = 0; st < 2; st++) begin
        doReset();
        if (st == 1) sendWord(5'b00000, "R4");  // moves disparity to +2
        sendWord(5'(w), ($countones(5'(w)) == 2 || $countones(5'(w)) == 3) ? "R2" : "R4");
        // R8: record code owner
        if (seenBy[outCode] != -1) check(seenBy[outCode] == w, "R8", seenBy[outCode], w);
        else seenBy[outCode] = w;
      end
    end

    // R3: stored member sent as is from zero disparity
    for (int k = 0; k < 12; k++) begin
      doReset();
      sendWord(PAIR_TAB[k][10:6], "R3");
      check(outCode == PAIR_TAB[k][5:0], "R3", outCode, PAIR_TAB[k][5:0]);
    end

    // R1/R7: idle cycles keep code and disparity, no strobe
    doReset();
    sendWord(5'b11111, "R4");
    held = outCode;
    heldRd = runDisp;
    inWord = 5'b00000;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", outValid, 0);
    check(outCode == held, "R7", outCode, held);
    check(runDisp == heldRd, "R7", runDisp, heldRd);

    // R6: reset mid-stream at +2 returns to zero
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(runDisp == 2'b00, "R6", runDisp, 0);
    check(outValid == 1'b0, "R6", outValid, 0);
    rst = 1'b0;
    modelRd = 0;

    // Random stream with idle gaps against the model
    for (int n = 0; n < 400; n++) begin
      sendWord(5'($urandom_range(0, 31)), "R4");
      check(modelRd >= -2 && modelRd <= 2, "R5", modelRd, 0);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule